// File: doc/BRIEF.md
# Masked Internal Processor Register File

This block holds the internal control registers of a processor core behind a single indexed access port. Each index selects a register class: read-write with a fixed per-register write mask, a cycle-counter register whose low half is taken live from a free-running count, clear-on-write registers, read-only registers, write-only registers, and two write-only invalidate registers that emit one-cycle strobes. Accessing an index in a direction its class does not allow, or touching an index outside the map, raises a one-cycle fault pulse and leaves all stored state untouched.

A read is requested with `rd_en` and `rd_idx`. The result appears on `rd_data` one clock later and holds until the next read. A write is requested with `wr_en`, `wr_idx` and `wr_data` and takes effect at the same edge. Reads and writes may be issued in the same cycle. A read of the index being written returns the value from before the write.

Top module: `ipr_file`

## Requirements
- R1: After reset every stored register is zero, `rd_data` is zero, and `fault`, `inv_all_stb` and `inv_proc_stb` are low.
- R2: Scratch indices 0 to NUM_SCRATCH-1 and vector base index 16 store all 64 bits. `rd_data` shows the addressed value one cycle after `rd_en`, shows the pre-write value when the same index is written in that cycle, and holds while `rd_en` is low.
- R3: A read of cycle register index 17 returns bits 63:32 from the stored register and bits 31:0 from `cyc_cnt`, sampled in the read cycle. A write to index 17 stores all 64 bits.
- R4: Writes to the trap-request index 18 and the trap-enable index 19 keep bits 3:0 only. Writes to the priority-level index 20 keep bits 4:0 only.
- R5: Writes to the current-mode index 21 keep bits 4:3 (mask 0x18). The cache-mode index 23 and the miss-queue-mode index 24 keep mask 0x3f. The cache-test index 25 keeps mask 0x1ffb.
- R6: Writes to the instruction address-space index 26 keep mask 0x7f0. The data address-space index 27 keeps bits 63:57. The page-table base index 28 keeps bits 63:30.
- R7: Indices 29 (exception summary) and 30 (exception mask) accept writes without fault, and any write leaves them reading zero.
- R8: A write to a read-only index (31 interrupt id, 32 serial receive, 33 translation status, 34 entry staging) faults and changes no register. Reading those indices returns zero without fault.
- R9: A read of a write-only index (22 alternate mode, 35 interrupt clear, 36 serial transmit, 37 cache flush, 38, 39) faults and returns `rd_data` zero. A write to those indices does not fault.
- R10: Any read or write of an index outside the map (NUM_SCRATCH to 15, and 40 to 63) faults. Such a write changes no register.
- R11: `fault` goes high in the cycle after an illegal access, for exactly that one cycle per offending cycle. Legal accesses never raise it.
- R12: A write to index 38 pulses `inv_all_stb` and a write to index 39 pulses `inv_proc_stb`, each for one cycle in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDX_W | Read index |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Write index |
| wr_data | input | DATA_W | Write data |
| cyc_cnt | input | DATA_W/2 | Free-running cycle count |
| rd_data | output | DATA_W | Registered read result |
| fault | output | 1 | Illegal-access pulse |
| inv_all_stb | output | 1 | Invalidate-all strobe |
| inv_proc_stb | output | 1 | Invalidate-by-process strobe |

## Verification
Every masked register is written with all ones, with alternating 0x5555/0xAAAA words, and with a walking single bit. This separates a wrong mask from a mask applied to the wrong index. The cycle register is read with differing stored upper halves and live counts, so a swapped or stale half shows up. Back-to-back illegal accesses, followed by legal ones, check the pulse shape of the fault. A same-cycle read and write of one index checks read-before-write ordering. A long mixed run of random indices, directions and data, compared every cycle with a behavioural model, covers the class decode across the whole index space.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

   typedef enum logic [3:0] {
      K_NONE, K_RW, K_CYC, K_CLR, K_RO, K_WO, K_INV_ALL, K_INV_PROC
   } ipr_kind_e;

   localparam int SCRATCH_LIMIT = 16;

   localparam int IX_VBASE    = 16;
   localparam int IX_CYC      = 17;
   localparam int IX_TRAPREQ  = 18;
   localparam int IX_TRAPEN   = 19;
   localparam int IX_PRIO     = 20;
   localparam int IX_CURMODE  = 21;
   localparam int IX_ALTMODE  = 22;
   localparam int IX_CMODE    = 23;
   localparam int IX_QMODE    = 24;
   localparam int IX_CTEST    = 25;
   localparam int IX_IASPACE  = 26;
   localparam int IX_DASPACE  = 27;
   localparam int IX_PTBASE   = 28;
   localparam int IX_XSUM     = 29;
   localparam int IX_XMSK     = 30;
   localparam int IX_INTID    = 31;
   localparam int IX_SERRX    = 32;
   localparam int IX_XLSTAT   = 33;
   localparam int IX_STAGE    = 34;
   localparam int IX_INTCLR   = 35;
   localparam int IX_SERTX    = 36;
   localparam int IX_CFLUSH   = 37;
   localparam int IX_INV_ALL  = 38;
   localparam int IX_INV_PROC = 39;

   function automatic ipr_kind_e kind_of(int idx, int n_scratch);
      if (idx < n_scratch) return K_RW;
      case (idx)
         IX_VBASE, IX_TRAPREQ, IX_TRAPEN, IX_PRIO, IX_CURMODE,
         IX_CMODE, IX_QMODE, IX_CTEST, IX_IASPACE, IX_DASPACE,
         IX_PTBASE:                                return K_RW;
         IX_CYC:                                   return K_CYC;
         IX_XSUM, IX_XMSK:                         return K_CLR;
         IX_INTID, IX_SERRX, IX_XLSTAT, IX_STAGE:  return K_RO;
         IX_ALTMODE, IX_INTCLR, IX_SERTX, IX_CFLUSH: return K_WO;
         IX_INV_ALL:                               return K_INV_ALL;
         IX_INV_PROC:                              return K_INV_PROC;
         default:                                  return K_NONE;
      endcase
   endfunction

   function automatic logic [63:0] mask_of(int idx);
      case (idx)
         IX_TRAPREQ, IX_TRAPEN: return 64'h0000_0000_0000_000F;
         IX_PRIO:               return 64'h0000_0000_0000_001F;
         IX_CURMODE:            return 64'h0000_0000_0000_0018;
         IX_CMODE, IX_QMODE:    return 64'h0000_0000_0000_003F;
         IX_CTEST:              return 64'h0000_0000_0000_1FFB;
         IX_IASPACE:            return 64'h0000_0000_0000_07F0;
         IX_DASPACE:            return 64'hFE00_0000_0000_0000;
         IX_PTBASE:             return 64'hFFFF_FFFF_C000_0000;
         default:               return '1;
      endcase
   endfunction

   function automatic logic kind_readable(ipr_kind_e k);
      return (k == K_RW) || (k == K_CYC) || (k == K_CLR) || (k == K_RO);
   endfunction

   function automatic logic kind_writable(ipr_kind_e k);
      return (k == K_RW) || (k == K_CYC) || (k == K_CLR) || (k == K_WO) ||
             (k == K_INV_ALL) || (k == K_INV_PROC);
   endfunction

endpackage

// File: rtl/ipr_decode.sv
module ipr_decode
   import ipr_pkg::*;
#(
   parameter int IDX_W       = 6,
   parameter int NUM_SCRATCH = 8
) (
   input  logic [IDX_W-1:0] idx,
   output ipr_kind_e        kind
);

   always_comb begin
      kind = kind_of(int'(idx), NUM_SCRATCH);
   end

endmodule

// File: rtl/ipr_cell.sv
module ipr_cell #(
   parameter int          W    = 64,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (we)  q <= d & MASK;
   end

   // R8: a register only moves when its own enable was high
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

endmodule

// File: rtl/ipr_file.sv
module ipr_file
   import ipr_pkg::*;
#(
   parameter int DATA_W      = 64,
   parameter int IDX_W       = 6,
   parameter int NUM_SCRATCH = 8,
   parameter int CYC_W       = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [CYC_W-1:0]  cyc_cnt,
   output logic [DATA_W-1:0] rd_data,
   output logic              fault,
   output logic              inv_all_stb,
   output logic              inv_proc_stb
);

   localparam int NREG = 2 ** IDX_W;
   localparam int HI_W = DATA_W - CYC_W;

   if (DATA_W != 64)                  begin : g_chk_w   $error("DATA_W must be 64"); end
   if (CYC_W != DATA_W / 2)           begin : g_chk_c   $error("CYC_W must be half of DATA_W"); end
   if (IDX_W < 6 || IDX_W > 8)        begin : g_chk_i   $error("IDX_W must be 6..8"); end
   if (NUM_SCRATCH < 1 || NUM_SCRATCH > SCRATCH_LIMIT)
                                      begin : g_chk_s   $error("NUM_SCRATCH out of range"); end

   ipr_kind_e rd_kind, wr_kind;

   ipr_decode #(.IDX_W(IDX_W), .NUM_SCRATCH(NUM_SCRATCH)) u_rd_dec (
      .idx (rd_idx), .kind(rd_kind));
   ipr_decode #(.IDX_W(IDX_W), .NUM_SCRATCH(NUM_SCRATCH)) u_wr_dec (
      .idx (wr_idx), .kind(wr_kind));

   logic rd_ok, wr_ok, wr_go;
   assign rd_ok = kind_readable(rd_kind);
   assign wr_ok = kind_writable(wr_kind);
   assign wr_go = wr_en && wr_ok;

   logic [DATA_W-1:0] store [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam ipr_kind_e K = kind_of(i, NUM_SCRATCH);
      if (K == K_RW || K == K_CYC) begin : g_cell
         ipr_cell #(.W(DATA_W), .MASK(mask_of(i))) u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (wr_go && (wr_idx == IDX_W'(i))),
            .d    (wr_data),
            .q    (store[i]));
      end else begin : g_zero
         assign store[i] = '0;
      end
   end

   logic [DATA_W-1:0] rd_val;
   always_comb begin
      rd_val = '0;
      if (rd_ok) begin
         if (rd_kind == K_CYC)
            rd_val = {store[rd_idx][DATA_W-1 -: HI_W], cyc_cnt};
         else
            rd_val = store[rd_idx];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data      <= '0;
         fault        <= 1'b0;
         inv_all_stb  <= 1'b0;
         inv_proc_stb <= 1'b0;
      end else begin
         if (rd_en) rd_data <= rd_val;
         fault        <= (rd_en && !rd_ok) || (wr_en && !wr_ok);
         inv_all_stb  <= wr_en && (wr_kind == K_INV_ALL);
         inv_proc_stb <= wr_en && (wr_kind == K_INV_PROC);
      end
   end

   // R11: a fault pulse always follows some access
   p_fault_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $past(rd_en || wr_en));

   // R3: low half of a cycle read comes from the live count
   p_cyc_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_idx == IDX_W'(IX_CYC)) |=> rd_data[CYC_W-1:0] == $past(cyc_cnt));

   // R2: read data holds between reads
   p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   // R12: strobe only after a write to its own index
   p_inv_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all_stb |-> $past(wr_en && wr_idx == IDX_W'(IX_INV_ALL)));

   // R12: the two strobes never coincide
   always_ff @(posedge clk) begin
      if (rst_n) p_stb_excl_r12: assert ($onehot0({inv_all_stb, inv_proc_stb}));
   end

endmodule

// File: tb/ipr_file_bench.sv
module ipr_file_bench;

   localparam int NS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [5:0]  rd_idx = '0, wr_idx = '0;
   logic [63:0] wr_data = '0;
   logic [31:0] cyc_cnt = '0;
   logic [63:0] rd_data;
   logic        fault, inv_all_stb, inv_proc_stb;

   int compared = 0, mismatched = 0;
   bit done = 0;

   always #5 clk = ~clk;

   ipr_file u_ipr_file (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .cyc_cnt(cyc_cnt),
      .rd_data(rd_data), .fault(fault),
      .inv_all_stb(inv_all_stb), .inv_proc_stb(inv_proc_stb));

   // model state
   logic [63:0] mem [64];
   logic [63:0] exp_rd = '0;
   logic        exp_fault = 0, exp_all = 0, exp_proc = 0;

   // 0 none,1 stored,2 cycle,3 clear,4 readonly,5 writeonly,6 inv all,7 inv proc
   function automatic int cls(int i);
      if (i < NS) return 1;
      if (i < 16) return 0;
      if (i == 16 || (i >= 18 && i <= 28 && i != 22)) return 1;
      if (i == 17) return 2;
      if (i == 29 || i == 30) return 3;
      if (i >= 31 && i <= 34) return 4;
      if (i == 22 || (i >= 35 && i <= 37)) return 5;
      if (i == 38) return 6;
      if (i == 39) return 7;
      return 0;
   endfunction

   function automatic logic [63:0] msk(int i);
      if (i == 18 || i == 19) return 64'hF;
      if (i == 20) return 64'h1F;
      if (i == 21) return 64'h18;
      if (i == 23 || i == 24) return 64'h3F;
      if (i == 25) return 64'h1FFB;
      if (i == 26) return 64'h7F0;
      if (i == 27) return {7'h7F, 57'h0};
      if (i == 28) return {34'h3_FFFF_FFFF, 30'h0};
      return '1;
   endfunction

   task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic step(bit re, int ri, bit we, int wi, logic [63:0] wd, string req);
      int rc, wc;
      rd_en = re; rd_idx = 6'(ri); wr_en = we; wr_idx = 6'(wi); wr_data = wd;
      cyc_cnt = $urandom;
      rc = cls(ri); wc = cls(wi);
      if (re) begin
         if (rc == 1 || rc == 3 || rc == 4) exp_rd = mem[ri];
         else if (rc == 2) exp_rd = {mem[ri][63:32], cyc_cnt};
         else exp_rd = '0;
      end
      exp_fault = (re && (rc == 0 || rc >= 5)) || (we && (wc == 0 || wc == 4));
      exp_all  = we && wc == 6;
      exp_proc = we && wc == 7;
      if (we && (wc == 1 || wc == 2)) mem[wi] = wd & msk(wi);
      @(posedge clk);
      @(negedge clk);
      cmp(req, "rd_data", rd_data, exp_rd);
      cmp(req, "fault", {63'b0, fault}, {63'b0, exp_fault});
      cmp(req, "inv_all_stb", {63'b0, inv_all_stb}, {63'b0, exp_all});
      cmp(req, "inv_proc_stb", {63'b0, inv_proc_stb}, {63'b0, exp_proc});
   endtask

   task automatic wr(int i, logic [63:0] d, string req); step(0, 0, 1, i, d, req); endtask
   task automatic rd(int i, string req);                 step(1, i, 0, 0, '0, req); endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      cmp("R1", "rd_data", rd_data, '0);
      cmp("R1", "fault", {63'b0, fault}, '0);
      for (int i = 0; i < 40; i++) if (cls(i) == 1 || cls(i) == 2) rd(i, "R1");

      // R2: full storage, several patterns, read-before-write, hold
      for (int i = 0; i < NS; i++) begin wr(i, 64'h5555_AAAA_0F0F_F0F0 ^ 64'(i), "R2"); rd(i, "R2"); end
      wr(16, '1, "R2"); rd(16, "R2");
      step(1, 16, 1, 16, 64'h0123_4567_89AB_CDEF, "R2");
      rd(16, "R2");
      step(0, 0, 0, 0, '0, "R2");

      // R3: cycle register composite read
      wr(17, 64'hDEAD_BEEF_1234_5678, "R3"); rd(17, "R3"); rd(17, "R3");
      wr(17, 64'h0000_0001_FFFF_FFFF, "R3"); rd(17, "R3");

      // R4 R5 R6: masks under ones, alternating and walking bits
      for (int i = 18; i <= 28; i++) begin
         string t;
         if (i == 22) continue;
         t = (i <= 20) ? "R4" : (i <= 25) ? "R5" : "R6";
         wr(i, '1, t);                     rd(i, t);
         wr(i, 64'h5555_5555_5555_5555, t); rd(i, t);
         wr(i, 64'hAAAA_AAAA_AAAA_AAAA, t); rd(i, t);
         for (int b = 0; b < 64; b += 7) begin wr(i, 64'h1 << b, t); rd(i, t); end
      end

      // R7: clear on write
      wr(29, '1, "R7"); rd(29, "R7");
      wr(30, 64'h1234, "R7"); rd(30, "R7");

      // R8: read-only
      for (int i = 31; i <= 34; i++) begin wr(i, '1, "R8"); rd(i, "R8"); end
      rd(16, "R8");

      // R9: write-only
      rd(16, "R9");
      for (int i = 35; i <= 39; i++) begin rd(i, "R9"); wr(i, 64'h77, "R9"); end
      rd(22, "R9"); wr(22, '1, "R9");

      // R10: unknown indices
      rd(NS, "R10"); wr(NS, '1, "R10"); rd(45, "R10"); wr(63, '1, "R10");
      rd(0, "R10");

      // R11: pulse shape, back-to-back and drop
      step(1, 50, 1, 50, '1, "R11");
      step(1, 51, 0, 0, '0, "R11");
      step(1, 0, 1, 1, 64'h9, "R11");
      step(0, 0, 0, 0, '0, "R11");

      // R12: strobes
      wr(38, '0, "R12"); step(0, 0, 0, 0, '0, "R12");
      wr(39, '0, "R12"); wr(38, '1, "R12"); wr(39, '1, "R12");
      step(0, 0, 0, 0, '0, "R12");

      // mixed run
      for (int n = 0; n < 3000; n++)
         step($urandom_range(0, 1), $urandom_range(0, 63), $urandom_range(0, 1),
              $urandom_range(0, 63), {$urandom, $urandom}, "R11");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #(1_500_000);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule